// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block turns a short packet into the differential line signals of a low-speed USB link. After a start pulse it enables the pin drivers and holds the idle J state for one bit time. It then shifts out a sync byte and the packet bytes, each least-significant bit first, with NRZI coding and bit stuffing. It closes the packet with an end-of-packet marker and releases the pins. Every line symbol lasts a fixed number of clock cycles, 12 by default.

In data mode the block pulls payload bytes one at a time from a byte source at the moment each byte is needed. In handshake mode it needs no byte source: it sends the sync byte and then one PID byte that was captured when the packet started. A staged device address is copied into the active address register when a data packet finishes. A handshake never copies it.

Top module: `usb_ls_tx`

## Requirements
- R1: Each line symbol (lead-in, data bit, stuff bit, SE0, final J) stays unchanged on dp_out/dm_out for exactly CLKS_PER_BIT (12) clock cycles.
- R2: A start pulse seen while idle raises oe and busy at the next clock edge. For the first bit time the lines show J, encoded as dp_out=0, dm_out=1.
- R3: After the lead-in the block sends the sync byte 0x80 and then the packet bytes, each least-significant bit first. A 0 bit flips the line between J and K (K is dp_out=1, dm_out=0), and a 1 bit keeps the line as it is.
- R4: After six 1 bits in a row the block inserts one extra flip and clears the count of 1s. This also applies after the last bit before the end of packet. The count starts from zero at the sync byte.
- R5: In data mode (hs_mode=0 at start) the block fetches pay_len payload bytes. For each byte it raises byte_req for one cycle and takes byte_in in that same cycle. A pay_len of 0 is treated as 1, and a value above MAX_BYTES-1 (11) is treated as 11.
- R6: In handshake mode (hs_mode=1 at start) the packet is the sync byte followed by hs_pid, and byte_req never rises.
- R7: After the last bit the lines show SE0 (both 0) for two bit times and then J for one bit time. At the next edge oe and busy fall, the outputs go to 0, and done is high for exactly one cycle.
- R8: A write to the staging register (addr_stage_we) does not change dev_addr. dev_addr takes the staged value when a data packet ends and keeps its value when a handshake packet ends.
- R9: A start pulse while busy has no effect: the current packet runs on unchanged, and no second packet follows it.
- R10: While reset is held, oe, busy, done, dp_out, dm_out and dev_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet (sampled while idle) |
| hs_mode | input | 1 | 1: send handshake PID only; 0: data packet |
| hs_pid | input | 8 | PID byte for handshake mode |
| pay_len | input | LEN_W (4) | Number of payload bytes in data mode |
| byte_req | output | 1 | One-cycle request for the next payload byte |
| byte_in | input | 8 | Payload byte, taken in the byte_req cycle |
| addr_stage_we | input | 1 | Write strobe for the staged address |
| addr_stage | input | ADDR_W (7) | Staged device address value |
| dev_addr | output | ADDR_W (7) | Active device address |
| busy | output | 1 | High from start to pin release |
| done | output | 1 | One-cycle pulse after pin release |
| dp_out | output | 1 | D+ drive value |
| dm_out | output | 1 | D- drive value |
| oe | output | 1 | Drive enable for both pins |

## Verification
The bench runs handshake PIDs and data payloads that exercise different parts of the encoder. Incrementing bytes mostly produce line flips. Runs of 0xFF force stuff bits inside bytes and across byte borders. A trailing 0xFC forces a stuff bit right before the end of packet. An all-zero maximum-length packet flips the line on every bit and never stuffs. Payload lengths of 0 and 15 check that out-of-range lengths are clamped, which shows up in the number of bytes fetched and the length of the packet. Alternating handshake and data packets, each after a new staged address, show whether the address commit depends on the packet kind. A start pulse in the middle of a packet shows whether the block can be restarted while busy.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_DATA,
      PH_SE0A,
      PH_SE0B,
      PH_TAIL
   } tx_phase_t;

   // encoded as {dp, dm}
   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_J   = 2'b01,
      LN_K   = 2'b10
   } line_t;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_J,
      OP_SE0,
      OP_BIT,
      OP_STUFF
   } line_op_t;

   localparam logic [7:0] SYNC_BYTE = 8'h80;
   localparam int         BYTE_W    = 8;

endpackage

// File: rtl/usb_ls_tx_bittimer.sv
module usb_ls_tx_bittimer #(
   parameter int CLKS_PER_BIT = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
   localparam bit IS_POW2 = ((CLKS_PER_BIT & (CLKS_PER_BIT - 1)) == 0);

   if (CLKS_PER_BIT < 2) begin : g_bad_period
      $error("CLKS_PER_BIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   if (IS_POW2) begin : g_wrap
      // counter wraps by itself; terminal count is all ones
      assign tick = run && (&cnt);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt <= '0;
         else if (!run) cnt <= '0;
         else          cnt <= cnt + CW'(1);
      end
   end else begin : g_cmp
      assign tick = run && (cnt == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt <= '0;
         else if (!run || tick) cnt <= '0;
         else                   cnt <= cnt + CW'(1);
      end
   end

   p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

endmodule

// File: rtl/usb_ls_tx_linecoder.sv
module usb_ls_tx_linecoder
   import usb_ls_tx_pkg::*;
#(
   parameter int STUFF_RUN = 6
) (
   input  logic     clk,
   input  logic     rst_n,
   input  line_op_t op,
   input  logic     bit_val,
   output line_t    line,
   output logic     stuff_due
);
   localparam int RW = $clog2(STUFF_RUN + 1);

   if (STUFF_RUN < 1) begin : g_bad_run
      $error("STUFF_RUN must be at least 1");
   end

   logic [RW-1:0] ones;

   function automatic line_t flip(input line_t l);
      return (l == LN_K) ? LN_J : LN_K;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line <= LN_J;
         ones <= '0;
      end else begin
         unique case (op)
            OP_J: begin
               line <= LN_J;
               ones <= '0;
            end
            OP_SE0: begin
               line <= LN_SE0;
               ones <= '0;
            end
            OP_BIT: begin
               if (!bit_val) line <= flip(line);
               ones <= bit_val ? ones + RW'(1) : '0;
            end
            OP_STUFF: begin
               line <= flip(line);
               ones <= '0;
            end
            default: ;
         endcase
      end
   end

   assign stuff_due = (ones == RW'(STUFF_RUN));

   p_run_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= RW'(STUFF_RUN));

   p_stuff_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_STUFF) |=> (line != $past(line)) && (line != LN_SE0));

   p_one_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_BIT && bit_val) |=> $stable(line));

endmodule

// File: rtl/usb_ls_tx_sequencer.sv
module usb_ls_tx_sequencer
   import usb_ls_tx_pkg::*;
#(
   parameter int MAX_BYTES = 12,
   parameter int LEN_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              hs_mode,
   input  logic [7:0]        hs_pid,
   input  logic [LEN_W-1:0]  pay_len,
   input  logic [7:0]        byte_in,
   input  logic              stuff_due,
   output tx_phase_t         phase,
   output line_op_t          op,
   output logic              bit_val,
   output logic              byte_req,
   output logic              fin,
   output logic              commit
);
   localparam int MAXP = MAX_BYTES - 1;
   localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

   tx_phase_t         phase_n;
   logic [7:0]        sh, sh_n;
   logic [2:0]        bidx, bidx_n;
   logic [LEN_W-1:0]  left, left_n;
   logic              hs_r, hs_n;
   logic [7:0]        pid_r, pid_n;
   logic [7:0]        nb;

   function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
      if (l == '0)                  return LEN_W'(1);
      else if (int'(l) > MAXP)      return LEN_W'(MAXP);
      else                          return l;
   endfunction

   always_comb begin
      phase_n  = phase;
      sh_n     = sh;
      bidx_n   = bidx;
      left_n   = left;
      hs_n     = hs_r;
      pid_n    = pid_r;
      op       = OP_NONE;
      bit_val  = 1'b0;
      byte_req = 1'b0;
      fin      = 1'b0;
      commit   = 1'b0;
      nb       = hs_r ? pid_r : byte_in;
      unique case (phase)
         PH_IDLE: if (start) begin
            phase_n = PH_LEAD;
            op      = OP_J;
            hs_n    = hs_mode;
            pid_n   = hs_pid;
            left_n  = hs_mode ? LEN_W'(1) : clamp_len(pay_len);
            sh_n    = SYNC_BYTE;
            bidx_n  = '0;
         end
         PH_LEAD: if (tick) begin
            phase_n = PH_DATA;
            op      = OP_BIT;
            bit_val = sh[0];
         end
         PH_DATA: if (tick) begin
            if (stuff_due) begin
               op = OP_STUFF;
            end else if (bidx != LAST_BIT) begin
               bidx_n  = bidx + 3'd1;
               sh_n    = sh >> 1;
               op      = OP_BIT;
               bit_val = sh[1];
            end else if (left != '0) begin
               byte_req = !hs_r;
               sh_n     = nb;
               bidx_n   = '0;
               left_n   = left - LEN_W'(1);
               op       = OP_BIT;
               bit_val  = nb[0];
            end else begin
               op      = OP_SE0;
               phase_n = PH_SE0A;
            end
         end
         PH_SE0A: if (tick) phase_n = PH_SE0B;
         PH_SE0B: if (tick) begin
            phase_n = PH_TAIL;
            op      = OP_J;
         end
         PH_TAIL: if (tick) begin
            phase_n = PH_IDLE;
            fin     = 1'b1;
            commit  = !hs_r;
         end
         default: phase_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         sh    <= '0;
         bidx  <= '0;
         left  <= '0;
         hs_r  <= 1'b0;
         pid_r <= '0;
      end else begin
         phase <= phase_n;
         sh    <= sh_n;
         bidx  <= bidx_n;
         left  <= left_n;
         hs_r  <= hs_n;
         pid_r <= pid_n;
      end
   end

   p_req_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_req |-> (phase == PH_DATA) && tick);

   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && start && !tick) |=> $stable(phase));

   p_left_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(left) <= MAXP);

endmodule

// File: rtl/usb_ls_tx_addrreg.sv
module usb_ls_tx_addrreg #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_we,
   input  logic [ADDR_W-1:0] stage_val,
   input  logic              commit,
   output logic [ADDR_W-1:0] dev_addr
);
   logic [ADDR_W-1:0] staged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged   <= '0;
         dev_addr <= '0;
      end else begin
         if (stage_we) staged   <= stage_val;
         if (commit)   dev_addr <= staged;
      end
   end

   p_commit_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !stage_we) |=> dev_addr == $past(staged));

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
   import usb_ls_tx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 12,
   parameter int MAX_BYTES    = 12,
   parameter int ADDR_W       = 7,
   parameter int STUFF_RUN    = 6,
   localparam int LEN_W       = $clog2(MAX_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              hs_mode,
   input  logic [7:0]        hs_pid,
   input  logic [LEN_W-1:0]  pay_len,
   output logic              byte_req,
   input  logic [7:0]        byte_in,
   input  logic              addr_stage_we,
   input  logic [ADDR_W-1:0] addr_stage,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              busy,
   output logic              done,
   output logic              dp_out,
   output logic              dm_out,
   output logic              oe
);
   if (MAX_BYTES < 2 || MAX_BYTES > 16) begin : g_bad_bytes
      $error("MAX_BYTES must lie in 2..16");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   tx_phase_t phase;
   line_op_t  op;
   line_t     line;
   logic      tick, bit_val, stuff_due, fin, commit, run;

   assign run = (phase != PH_IDLE);

   usb_ls_tx_bittimer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   usb_ls_tx_sequencer #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .start     (start),
      .hs_mode   (hs_mode),
      .hs_pid    (hs_pid),
      .pay_len   (pay_len),
      .byte_in   (byte_in),
      .stuff_due (stuff_due),
      .phase     (phase),
      .op        (op),
      .bit_val   (bit_val),
      .byte_req  (byte_req),
      .fin       (fin),
      .commit    (commit)
   );

   usb_ls_tx_linecoder #(.STUFF_RUN(STUFF_RUN)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .bit_val   (bit_val),
      .line      (line),
      .stuff_due (stuff_due)
   );

   usb_ls_tx_addrreg #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .stage_we  (addr_stage_we),
      .stage_val (addr_stage),
      .commit    (commit),
      .dev_addr  (dev_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= fin;
   end

   assign oe   = run;
   assign busy = run;
   assign {dp_out, dm_out} = run ? line : 2'b00;

   p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable({dp_out, dm_out}));

   p_lead_j_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> (!dp_out && dm_out));

   p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !oe && !dp_out && !dm_out);

   p_se0_in_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && !dp_out && !dm_out) |-> (phase == PH_SE0A || phase == PH_SE0B));

   p_addr_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_addr) |-> done);

endmodule

// File: tb/usb_ls_tx_tb_top.sv
`timescale 1ns/1ps
module usb_ls_tx_tb_top;
   localparam int CPB = 12;
   localparam int NV  = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start, hs_mode, addr_stage_we, src_clr;
   logic [7:0] hs_pid;
   logic [3:0] pay_len;
   logic [6:0] addr_stage;
   logic       byte_req, busy, done, dp_out, dm_out, oe;
   logic [7:0] byte_in;
   logic [6:0] dev_addr;

   logic [7:0] src [0:15];
   logic [4:0] idx;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   logic [1:0] exp_sym [0:199];
   string      exp_tag [0:199];
   int         ns;
   logic [6:0] exp_addr;

   // [100] handshake, [99:92] pid, [91:88] length, [87:0] payload (byte k at [8k+7:8k])
   localparam logic [100:0] VEC [NV] = '{
      {1'b1, 8'hD2, 4'd0,  88'h0},
      {1'b1, 8'h5A, 4'd0,  88'h0},
      {1'b0, 8'h00, 4'd3,  88'h030201},
      {1'b0, 8'h00, 4'd2,  88'hFFFF},
      {1'b0, 8'h00, 4'd1,  88'hFC},
      {1'b0, 8'h00, 4'd0,  88'h55},
      {1'b0, 8'h00, 4'd15, 88'h7EFF003FC381FFFE10E7A5},
      {1'b0, 8'h00, 4'd11, 88'h0}
   };

   always #2 clk = ~clk;

   usb_ls_tx dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .hs_mode       (hs_mode),
      .hs_pid        (hs_pid),
      .pay_len       (pay_len),
      .byte_req      (byte_req),
      .byte_in       (byte_in),
      .addr_stage_we (addr_stage_we),
      .addr_stage    (addr_stage),
      .dev_addr      (dev_addr),
      .busy          (busy),
      .done          (done),
      .dp_out        (dp_out),
      .dm_out        (dm_out),
      .oe            (oe)
   );

   assign byte_in = src[idx[3:0]];

   always @(posedge clk) begin
      if (src_clr)       idx <= '0;
      else if (byte_req) idx <= idx + 5'd1;
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] s, input string t);
      exp_sym[ns] = s;
      exp_tag[ns] = t;
      ns++;
   endtask

   // expected line symbols built from the requirements: J=01 K=10 SE0=00
   task automatic build(input bit hs, input logic [7:0] pid, input int n);
      logic [1:0] lvl;
      logic [7:0] b;
      int ones;
      ns = 0;
      lvl = 2'b01;
      push(lvl, "R2");
      ones = 0;
      for (int k = 0; k <= n; k++) begin
         b = (k == 0) ? 8'h80 : (hs ? pid : src[k-1]);
         for (int i = 0; i < 8; i++) begin
            if (!b[i]) lvl = ~lvl;
            push(lvl, "R3");
            ones = b[i] ? ones + 1 : 0;
            if (ones == 6) begin
               lvl = ~lvl;
               push(lvl, "R4");
               ones = 0;
            end
         end
      end
      push(2'b00, "R7");
      push(2'b00, "R7");
      push(2'b01, "R7");
   endtask

   task automatic run_packet(input int e, input bit inject, input logic [6:0] a);
      logic [100:0] v;
      int n;
      v = VEC[e];
      for (int k = 0; k < 16; k++) src[k] = (k < 11) ? v[8*k +: 8] : 8'hEE;
      hs_mode = v[100];
      hs_pid  = v[99:92];
      pay_len = v[91:88];
      n = v[100] ? 1 : (v[91:88] == 0 ? 1 : (v[91:88] > 11 ? 11 : int'(v[91:88])));
      build(v[100], v[99:92], n);
      src_clr = 1'b1;
      addr_stage = a;
      addr_stage_we = 1'b1;
      @(negedge clk);
      src_clr = 1'b0;
      addr_stage_we = 1'b0;
      chk(dev_addr == exp_addr, "R8", "stage write leaves dev_addr", dev_addr, exp_addr);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int s = 0; s < ns; s++) begin
         chk({dp_out, dm_out} == exp_sym[s] && oe && busy, exp_tag[s], "symbol start",
             {oe, busy, dp_out, dm_out}, {2'b11, exp_sym[s]});
         if (inject && s == 5) begin
            start = 1'b1;              // R9: start while busy
            @(negedge clk);
            start = 1'b0;
            repeat (CPB - 2) @(negedge clk);
         end else begin
            repeat (CPB - 1) @(negedge clk);
         end
         chk({dp_out, dm_out} == exp_sym[s], "R1", "symbol end",
             {dp_out, dm_out}, exp_sym[s]);
         @(negedge clk);
      end
      chk(done && !oe && !busy && !dp_out && !dm_out, "R7", "release",
          {done, oe, busy, dp_out, dm_out}, 5'b10000);
      if (v[100]) chk(idx == 0, "R6", "no fetch in handshake", idx, 0);
      else        chk(int'(idx) == n, "R5", "bytes fetched", idx, n);
      if (!v[100]) exp_addr = a;
      chk(dev_addr == exp_addr, "R8", "commit rule", dev_addr, exp_addr);
      @(negedge clk);
      chk(!done, "R7", "done one cycle", done, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      hs_mode = 1'b0;
      hs_pid = 8'h00;
      pay_len = 4'd0;
      addr_stage_we = 1'b0;
      addr_stage = 7'h00;
      src_clr = 1'b1;
      exp_addr = 7'h00;
      for (int k = 0; k < 16; k++) src[k] = 8'h00;
      repeat (3) @(negedge clk);
      chk(!oe && !busy && !done && !dp_out && !dm_out && dev_addr == 0, "R10", "in reset",
          {oe, busy, done, dp_out, dm_out, dev_addr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      src_clr = 1'b0;
      chk(!oe && !busy && !done && dev_addr == 0, "R10", "after reset",
          {oe, busy, done, dev_addr}, 0);

      for (int e = 0; e < NV; e++) run_packet(e, 1'b0, 7'(7'h11 + e));

      // start pulse in mid-packet must be ignored
      run_packet(2, 1'b1, 7'h7F);
      repeat (40) @(negedge clk);
      chk(!busy && !oe, "R9", "no relaunch", {busy, oe}, 0);

      // handshake after a staged write keeps the committed address
      run_packet(0, 1'b0, 7'h05);

      summary();
      $finish;
   end
endmodule